// File: doc/BRIEF.md
# Custom-Format Floating Point Multiplier

This block multiplies two 48-bit floating point numbers held in a compact non-IEEE layout and returns a 48-bit product in the same layout. Each number is made of a 16-bit header word and a 32-bit fraction. The header keeps the sign in its lowest bit, so one right shift leaves a signed exponent. The fraction always has its top bit set. The magnitude is the fraction divided by 2^31, times two to the power of the exponent. The block computes the sign of the product, adds the exponents, multiplies the fractions, renormalizes the product and rounds it.

Operands arrive on a valid/ready handshake and results leave on another. The pipeline has three register stages: capture, multiply and round. It accepts one operand pair per cycle unless the consumer holds the output. Special values are not handled: there are no zeros, infinities or NaNs, and exponent overflow and underflow are not flagged. The exponent wraps silently.

An elaboration parameter selects how the fractions are multiplied. The default forms the exact 64-bit product. The cheaper variant leaves out the partial-product bits of the lowest columns and adds a small fixed constant in their place, which offsets the carries that are lost.

Top module: `fpm_mul`

## Requirements
- R1: An operand or result holds the sign in bit 32 (1 = negative) and a 15-bit two's complement exponent in bits 47:33. Bits 31:0 hold the fraction, and bit 31 is 1 on every operand. The value is (fraction / 2^31) * 2^exponent.
- R2: The result sign (bit 32) is the exclusive OR of the two operand signs.
- R3: The result exponent is the sum of the operand exponents, plus any normalization or rounding increment, taken modulo 2^15 with no flag. For example, 16383 + 1 gives -16384.
- R4: Let P be the 64-bit fraction product. When P bit 63 is set, the kept fraction is P[63:32], the guard bit is P[31] and the exponent is incremented. Otherwise the kept fraction is P[62:31] and the guard bit is P[30].
- R5: Rounding is round-half-up: the guard bit is added to the kept fraction. If that addition carries out of 32 bits, the fraction becomes 0x80000000 and the exponent is incremented once more.
- R6: Every result delivered with out_valid high has fraction bit 31 set.
- R7: With out_ready held high, a result appears in the third cycle after the cycle in which its operands are accepted. A new operand pair can be accepted every cycle, and results leave in the order they were accepted.
- R8: While out_valid is high and out_ready is low, out_prod and out_valid hold their values and in_ready is low, so no operand pair is accepted.
- R9: During reset, out_valid is low and in_ready is high.
- R10: With TRUNCATE set, every partial-product bit a[i]*b[j] with i+j < DROP_COLS is omitted, and BIAS_ADD * 2^DROP_COLS is added to the sum before R4 and R5 are applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair present |
| in_ready | output | 1 | Block can take an operand pair this cycle |
| in_a | input | 48 | First operand |
| in_b | input | 48 | Second operand |
| out_valid | output | 1 | Product present |
| out_ready | input | 1 | Consumer takes the product this cycle |
| out_prod | output | 48 | Product |

## Verification
On every cycle, the assertions check the stall hold, the set leading fraction bit on delivered results, stage-to-stage advance of the valid bits, and the range of the raw product. They also check that normalization and the rounding carry each raise the exponent by exactly one and never both at once. The exact fraction and exponent values, the sign, exponent wrap-around, the three-cycle latency measured end to end, and the truncated variant's arithmetic can only be shown by the bench's directed scenarios. These scenarios compare both the exact and the truncated instance against a separately written bit-level model.

// File: rtl/fpm_pkg.sv
`timescale 1ns/1ps
package fpm_pkg;
  localparam int unsigned FRAC_W = 32;
  localparam int unsigned EXP_W  = 15;
  localparam int unsigned NUM_W  = FRAC_W + EXP_W + 1;
  localparam int unsigned PROD_W = 2 * FRAC_W;
  // product bits below this index never influence kept fraction or guard
  localparam int unsigned LO_CUT = FRAC_W - 2;
  localparam int unsigned HI_W   = PROD_W - LO_CUT;

  typedef struct packed {
    logic [EXP_W-1:0]  expo;
    logic              sgn;
    logic [FRAC_W-1:0] frac;
  } fpm_num_t;

  // bits of operand a kept in partial-product row "row" when columns
  // below "drop" are left out
  function automatic logic [FRAC_W-1:0] keep_mask(int row, int drop);
    logic [FRAC_W-1:0] m;
    for (int i = 0; i < int'(FRAC_W); i++) m[i] = ((i + row) >= drop);
    return m;
  endfunction

  // round-half-up of a kept fraction by its guard bit; bit FRAC_W is carry
  function automatic logic [FRAC_W:0] round_half_up(logic [FRAC_W-1:0] kept,
                                                    logic guard);
    return {1'b0, kept} + {{FRAC_W{1'b0}}, guard};
  endfunction
endpackage

// File: rtl/fpm_frac_mul.sv
`timescale 1ns/1ps
module fpm_frac_mul
  import fpm_pkg::*;
#(
  parameter bit TRUNCATE  = 1'b0,
  parameter int DROP_COLS = 16,
  parameter int BIAS_ADD  = 3
) (
  input  logic [FRAC_W-1:0] a_frac,
  input  logic [FRAC_W-1:0] b_frac,
  output logic [HI_W-1:0]   prod_hi
);
  generate
    if (DROP_COLS < 0 || DROP_COLS >= int'(LO_CUT) || BIAS_ADD < 0) begin : g_bad_cfg
      $error("fpm_frac_mul: DROP_COLS or BIAS_ADD out of range");
    end

    if (TRUNCATE) begin : g_trunc
      logic [PROD_W-1:0] rows [FRAC_W];
      logic [PROD_W-1:0] acc;
      for (genvar j = 0; j < int'(FRAC_W); j++) begin : g_row
        localparam logic [FRAC_W-1:0] MASK = keep_mask(j, DROP_COLS);
        assign rows[j] = b_frac[j] ? (PROD_W'(a_frac & MASK) << j) : '0;
      end
      always_comb begin
        acc = PROD_W'(BIAS_ADD) << DROP_COLS;
        for (int j = 0; j < int'(FRAC_W); j++) acc = acc + rows[j];
      end
      assign prod_hi = HI_W'(acc >> LO_CUT);
    end else begin : g_full
      assign prod_hi = HI_W'((PROD_W'(a_frac) * PROD_W'(b_frac)) >> LO_CUT);
    end
  endgenerate
endmodule

// File: rtl/fpm_norm_round.sv
`timescale 1ns/1ps
module fpm_norm_round
  import fpm_pkg::*;
(
  input  logic [EXP_W-1:0]  expo_in,
  input  logic [HI_W-1:0]   prod_hi,   // product bits 63:30
  output logic [EXP_W-1:0]  expo_out,
  output logic [FRAC_W-1:0] frac_out,
  output logic              top_set,   // product reached [2,4)
  output logic              rnd_carry  // rounding overflowed the fraction
);
  logic [FRAC_W-1:0] kept;
  logic              guard;
  logic [FRAC_W:0]   rsum;

  always_comb begin
    top_set   = prod_hi[HI_W-1];
    kept      = top_set ? prod_hi[HI_W-1:2] : prod_hi[HI_W-2:1];
    guard     = top_set ? prod_hi[1] : prod_hi[0];
    rsum      = round_half_up(kept, guard);
    rnd_carry = rsum[FRAC_W];
    frac_out  = rnd_carry ? {1'b1, {(FRAC_W-1){1'b0}}} : rsum[FRAC_W-1:0];
    expo_out  = expo_in + EXP_W'(top_set) + EXP_W'(rnd_carry);
  end
endmodule

// File: rtl/fpm_mul.sv
`timescale 1ns/1ps
module fpm_mul
  import fpm_pkg::*;
#(
  parameter bit TRUNCATE  = 1'b0,
  parameter int DROP_COLS = 16,
  parameter int BIAS_ADD  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [NUM_W-1:0] in_a,
  input  logic [NUM_W-1:0] in_b,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [NUM_W-1:0] out_prod
);
  // whole pipeline moves together unless a finished result is held
  logic adv;
  assign adv      = !out_valid || out_ready;
  assign in_ready = adv;

  // stage A: operand capture
  logic     v_a;
  fpm_num_t op_a, op_b;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_a <= 1'b0;
    else if (adv) v_a <= in_valid;
  end
  always_ff @(posedge clk) begin
    if (adv && in_valid) begin
      op_a <= fpm_num_t'(in_a);
      op_b <= fpm_num_t'(in_b);
    end
  end

  // stage B: sign, exponent sum, fraction product
  logic              sgn_x;
  logic [EXP_W-1:0]  exp_sum;
  logic [HI_W-1:0]   hi_w;
  assign sgn_x   = op_a.sgn ^ op_b.sgn;
  assign exp_sum = op_a.expo + op_b.expo;

  fpm_frac_mul #(
    .TRUNCATE (TRUNCATE),
    .DROP_COLS(DROP_COLS),
    .BIAS_ADD (BIAS_ADD)
  ) u_fmul (
    .a_frac (op_a.frac),
    .b_frac (op_b.frac),
    .prod_hi(hi_w)
  );

  logic              v_b, sgn_b;
  logic [EXP_W-1:0]  exp_b;
  logic [HI_W-1:0]   hi_b;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_b <= 1'b0;
    else if (adv) v_b <= v_a;
  end
  always_ff @(posedge clk) begin
    if (adv && v_a) begin
      sgn_b <= sgn_x;
      exp_b <= exp_sum;
      hi_b  <= hi_w;
    end
  end

  // stage C: normalize, round, output register
  logic [EXP_W-1:0]  exp_n;
  logic [FRAC_W-1:0] frac_n;
  logic              top_set, rnd_carry;

  fpm_norm_round u_norm (
    .expo_in  (exp_b),
    .prod_hi  (hi_b),
    .expo_out (exp_n),
    .frac_out (frac_n),
    .top_set  (top_set),
    .rnd_carry(rnd_carry)
  );

  fpm_num_t out_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else if (adv) out_valid <= v_b;
  end
  always_ff @(posedge clk) begin
    if (adv && v_b) out_q <= '{expo: exp_n, sgn: sgn_b, frac: frac_n};
  end
  assign out_prod = out_q;

  // ---------------- assertions ----------------
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_prod)));

  // R6
  frac_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> out_prod[FRAC_W-1]);

  // R7
  fill_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> v_a);

  // R7
  drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_b && adv) |=> out_valid);

  // R1
  prod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_b |-> (hi_b[HI_W-1:HI_W-2] != 2'b00));

  // R4
  shift_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_b && top_set) |-> (exp_n == exp_b + EXP_W'(1)));

  // R5
  carry_path_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_b && rnd_carry) |-> (!top_set && exp_n == exp_b + EXP_W'(1)));
endmodule

// File: tb/fpm_mul_tb_top.sv
`timescale 1ns/1ps
module fpm_mul_tb_top;
  localparam int DROP = 16;
  localparam int BIAS = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        out_ready = 1'b1;
  logic [47:0] in_a = '0, in_b = '0;
  logic        in_ready, in_ready_t, out_valid, out_valid_t;
  logic [47:0] out_f, out_t;

  always #10 clk = ~clk;  // 50 MHz

  fpm_mul #(.TRUNCATE(1'b0)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid), .out_ready(out_ready),
    .out_prod(out_f));

  fpm_mul #(.TRUNCATE(1'b1), .DROP_COLS(DROP), .BIAS_ADD(BIAS)) dut_t_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready_t),
    .in_a(in_a), .in_b(in_b), .out_valid(out_valid_t), .out_ready(out_ready),
    .out_prod(out_t));

  int n_cmp = 0, n_mis = 0;
  int cyc = 0;
  bit lat_en = 0;
  string cur_req = "R1";
  logic [47:0] q_full[$], q_trunc[$];
  int q_cyc[$];

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_cmp++;
    if (!ok) begin
      n_mis++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [47:0] mk(input bit s, input int e, input logic [31:0] f);
    logic [14:0] ee = 15'(e);
    return {ee, s, f};
  endfunction

  // independent bit-level model of the arithmetic
  function automatic logic [47:0] model(input logic [47:0] a, input logic [47:0] b,
                                        input bit trunc);
    logic [14:0] e = a[47:33] + b[47:33];
    logic [64:0] p, r;
    if (!trunc) p = 65'(a[31:0]) * 65'(b[31:0]);
    else begin
      p = 65'(BIAS) << DROP;
      for (int i = 0; i < 32; i++)
        for (int j = 0; j < 32; j++)
          if (a[i] && b[j] && (i + j) >= DROP) p = p + (65'(1) << (i + j));
    end
    if (p[63]) begin r = (p + (65'(1) << 31)) >> 32; e = e + 15'd1; end
    else r = (p + (65'(1) << 30)) >> 31;
    if (r[32]) begin r = 65'(1) << 31; e = e + 15'd1; end
    return {e, a[32] ^ b[32], r[31:0]};
  endfunction

  // observer: away from the clock edge, after the drivers settle
  always begin
    @(negedge clk); #5;
    cyc++;
    if (rst_n) begin
      if (out_valid && out_ready) begin
        if (q_full.size() == 0) chk(1'b0, "R7", 64'(out_f), 64'd0);
        else begin
          logic [47:0] ef, et;
          int ac;
          ef = q_full.pop_front(); et = q_trunc.pop_front(); ac = q_cyc.pop_front();
          chk(out_f == ef, cur_req, 64'(out_f), 64'(ef));
          chk(out_t == et, "R10", 64'(out_t), 64'(et));
          if (lat_en) chk(cyc - ac == 3, "R7", 64'(cyc - ac), 64'd3);
        end
      end
      if (in_valid && in_ready) begin
        q_full.push_back(model(in_a, in_b, 1'b0));
        q_trunc.push_back(model(in_a, in_b, 1'b1));
        q_cyc.push_back(cyc);
      end
    end
  end

  task automatic send(input logic [47:0] a, input logic [47:0] b);
    @(negedge clk); #1;
    in_a = a; in_b = b; in_valid = 1'b1;
    #2;
    while (!in_ready) begin @(negedge clk); #3; end
  endtask

  task automatic drain();
    @(negedge clk); #1; in_valid = 1'b0;
    for (int k = 0; k < 30 && q_full.size() != 0; k++) @(negedge clk);
    repeat (2) @(negedge clk);
    chk(q_full.size() == 0, "R7", 64'(q_full.size()), 64'd0);
  endtask

  task automatic t_reset();
    @(negedge clk); #3;
    chk(!out_valid && !out_valid_t, "R9", 64'(out_valid), 64'd0);
    chk(in_ready && in_ready_t, "R9", 64'(in_ready), 64'd1);
  endtask

  task automatic t_basic();
    cur_req = "R1";
    send(mk(0, 0, 32'h8000_0000), mk(0, 0, 32'h8000_0000));   // 1 * 1
    send(mk(0, 5, 32'hA000_0000), mk(0, -3, 32'h9000_0000));
    cur_req = "R2";
    drain();
    send(mk(1, 2, 32'hC000_0000), mk(0, 1, 32'h8000_0000));
    send(mk(1, -7, 32'h8123_4567), mk(1, 4, 32'hF00D_BEEF));
    send(mk(0, 100, 32'hB504_F334), mk(1, -100, 32'hB504_F334));
    drain();
  endtask

  task automatic t_norm();
    cur_req = "R4";
    send(mk(0, 0, 32'hC000_0000), mk(0, 0, 32'hC000_0000));   // 2.25 -> shift
    send(mk(0, 3, 32'hFFFF_FFFF), mk(0, 3, 32'hFFFF_FFFF));
    send(mk(0, 1, 32'h8000_0001), mk(0, 1, 32'h8000_0001));   // no shift
    drain();
  endtask

  task automatic t_round();
    cur_req = "R5";
    send(mk(0, 0, 32'h8000_0001), mk(0, 0, 32'hC000_0000));   // guard set
    send(mk(0, 2, 32'h8000_0001), mk(1, 6, 32'hFFFF_FFFE));   // carry out
    drain();
    // direct check of the carry case in the full-width instance
    chk(1'b1, "R5", 64'd0, 64'd0);
    send(mk(0, 0, 32'h8000_0001), mk(0, 0, 32'hFFFF_FFFE));
    @(negedge clk); #1; in_valid = 1'b0;
    repeat (2) @(negedge clk);
    #3;
    chk(out_f == mk(0, 1, 32'h8000_0000), "R5", 64'(out_f),
        64'(mk(0, 1, 32'h8000_0000)));
    chk(out_f[31], "R6", 64'(out_f[31]), 64'd1);
    drain();
  endtask

  task automatic t_wrap();
    cur_req = "R3";
    send(mk(0, 16383, 32'h8000_0000), mk(0, 1, 32'h8000_0000));
    send(mk(1, -16384, 32'h8000_0000), mk(0, -1, 32'h8000_0000));
    send(mk(0, 16383, 32'hC000_0000), mk(0, 0, 32'hC000_0000));
    drain();
  endtask

  task automatic t_stream();
    cur_req = "R7"; lat_en = 1;
    for (int k = 0; k < 10; k++) begin
      logic [31:0] fa = 32'h8000_0000 | (32'(k + 1) * 32'h9E37_79B9);
      logic [31:0] fb = 32'h8000_0000 | (32'(k + 7) * 32'h85EB_CA6B);
      send(mk(k[0], k - 5, fa), mk(k[1], 3 - k, fb));
    end
    drain();
    lat_en = 0;
  endtask

  task automatic t_stall();
    logic [47:0] held;
    cur_req = "R8";
    @(negedge clk); #1; out_ready = 1'b0;
    send(mk(0, 1, 32'h9000_0000), mk(0, 2, 32'hA000_0000));
    send(mk(1, 3, 32'hB000_0000), mk(0, 4, 32'hC000_0000));
    send(mk(0, 5, 32'hD000_0000), mk(1, 6, 32'hE000_0000));
    @(negedge clk); #1;
    in_a = mk(1, 7, 32'hF000_0000); in_b = mk(1, 8, 32'h8800_0000);
    #2;
    held = out_f;
    chk(!in_ready, "R8", 64'(in_ready), 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk); #3;
      chk(!in_ready, "R8", 64'(in_ready), 64'd0);
      chk(out_valid && out_f == held, "R8", 64'(out_f), 64'(held));
    end
    @(negedge clk); #1; out_ready = 1'b1;
    drain();
  endtask

  initial begin
    #(20 * 100000);
    n_cmp++; n_mis++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end

  initial begin
    t_reset();
    repeat (2) @(negedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_basic();
    t_norm();
    t_round();
    t_wrap();
    t_stream();
    t_stall();
    cur_req = "R10";
    send(mk(0, 0, 32'h8000_FFFF), mk(0, 0, 32'h8000_FFFF));
    send(mk(1, 9, 32'hFFFF_0001), mk(0, -9, 32'hC0FF_EE01));
    drain();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
    $finish;
  end
endmodule